// File: doc/BRIEF.md
# Dual-Bank Flash Command Interpreter

This block sits in front of a two-bank flash memory model. It turns bus write cycles into per-bank read modes and operations. Each bank keeps its own read mode: array data, status register, identification, or query area. Each bank also keeps its own status register. A two-cycle erase sequence that passes the protection check hands a start pulse, with the bank and block, to an external program/erase engine. That engine later reports completion on a per-bank done line. The cell array, the real timing and the query table contents are stubs.

Reads are synchronous. A read strobe with an address returns, one clock later, a data byte and a source code that names where the byte came from. The bank is selected by the top address bit: 0 is the bottom bank and 1 is the top bank. The block index within the bank is in the next `log2(BLK_PER_BANK)` bits. The two lowest bits give the offset within the identification space.

Top module: `dbflash_cmd_ctrl`

## Requirements
- R1: After reset both banks are in array read mode. Both status registers read 0x80, where bit 7 is ready. `rd_valid` and `eng_start` are low.
- R2: Command 0xFF returns the addressed bank to array mode. `rd_valid` rises exactly one clock after `rd_en`. An array read returns data = addr[7:0] with source 0.
- R3: While a bank is busy, every command to it except 0xFF-free status entry (0x70) is ignored, including 0xFF. The same command to the idle bank takes effect.
- R4: Command 0x70 is accepted at any time, even while busy. Later reads of that bank return its status register with source 1. Bit 7 of the status register is 1 when the bank is ready and 0 when it is busy.
- R5: Command 0x90 to the bottom bank makes bottom reads return identification data with source 2. Offset 0 returns MFR_CODE (0x5A). Offset 1 returns DEV_CODE (0xC3). Offset 2 returns the addressed block's lock bit in bit 0. Offset 3 returns 0. Command 0x90 to the top bank makes top reads return only the addressed block's lock bit, with source 3.
- R6: Command 0x98 to the bottom bank makes bottom reads return ~addr[7:0] with source 4. Command 0x98 to the top bank is treated as unrecognised.
- R7: Command 0x50 zeros status bits 1, 3, 4 and 5 of the addressed bank and puts it in array mode.
- R8: Command 0x20 followed by 0xD0 to the same bank on an unlocked block raises `eng_start` for one cycle, during the confirm write, with `eng_bank` and `eng_blk`. The bank then reads busy in status mode until its `eng_done` bit pulses.
- R9: A confirm on a block whose `lock_map` bit is set gives no start. It sets status bits 5 and 1 and leaves the bank ready in status mode.
- R10: After 0x20, any second byte other than 0xD0 sets status bits 5 and 4 and returns the bank to array mode.
- R11: An unrecognised byte returns the bank to array mode and leaves its status register unchanged.
- R12: Status error bits stay set when a new erase starts. They clear only through 0x50.
- R13: A command to one bank leaves the other bank's mode and status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus address; MSB selects the bank |
| wdata | input | 8 | Command byte |
| lock_map | input | 2*BLK_PER_BANK | Per-block lock bits, index {bank, block} |
| rd_valid | output | 1 | Read result valid, one clock after rd_en |
| rd_data | output | 8 | Read data byte |
| rd_src | output | 3 | Source: 0 array, 1 status, 2 identification, 3 top protection, 4 query |
| eng_start | output | 1 | Erase start pulse to the engine |
| eng_bank | output | 1 | Bank of the started erase |
| eng_blk | output | log2(BLK_PER_BANK) | Block of the started erase |
| eng_done | input | 2 | Per-bank completion pulse from the engine |

## Verification
The table walk moves each bank through every read mode in turn and reads both banks after each command. The source code and data pattern differ per mode, so a mode wrongly copied to the other bank shows up as a wrong source. The two identification variants are told apart by reading locked and unlocked blocks in each bank.

Directed sequences then run erase attempts on a locked block and an unlocked block. They also run a wrong confirm byte, commands sent to a busy bank next to the same commands sent to the idle one, and clear-status after stacked errors. The resulting status bytes separate the protection, sequence and persistence behaviours bit by bit.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   typedef enum logic [1:0] {MD_ARRAY, MD_STATUS, MD_SIG, MD_CFI} mode_t;
   typedef enum logic [2:0] {
      SRC_ARRAY = 3'd0, SRC_STATUS = 3'd1, SRC_IDENT = 3'd2,
      SRC_PROT = 3'd3, SRC_CFI = 3'd4
   } src_t;

   localparam logic [7:0] CMD_READ    = 8'hFF;
   localparam logic [7:0] CMD_RSR     = 8'h70;
   localparam logic [7:0] CMD_SIG     = 8'h90;
   localparam logic [7:0] CMD_CFI     = 8'h98;
   localparam logic [7:0] CMD_CLR     = 8'h50;
   localparam logic [7:0] CMD_ERASE   = 8'h20;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;

   // bits 1,3,4,5 are cleared by the clear command
   localparam logic [7:0] CLR_MASK = 8'h3A;
   localparam int BIT_ERS  = 5;
   localparam int BIT_SEQ  = 4;
   localparam int BIT_PROT = 1;
endpackage

// File: rtl/dbf_bank_ctrl.sv
module dbf_bank_ctrl
   import dbf_pkg::*;
#(
   parameter bit IS_BOTTOM = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [7:0] cmd,
   input  logic       blk_locked,
   input  logic       done,
   output mode_t      mode,
   output logic       busy,
   output logic       pend,
   output logic [7:0] status,
   output logic       start
);
   logic [6:0] sticky;
   mode_t      query_next;

   // only the bottom bank owns the query area
   if (IS_BOTTOM) begin : g_query
      assign query_next = MD_CFI;
   end else begin : g_noquery
      assign query_next = MD_ARRAY;
   end

   assign start  = wr_hit && !busy && pend && (cmd == CMD_CONFIRM) && !blk_locked;
   assign status = {~busy, sticky};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= MD_ARRAY;
         busy   <= 1'b0;
         pend   <= 1'b0;
         sticky <= '0;
      end else begin
         if (done) busy <= 1'b0;
         if (wr_hit) begin
            if (busy) begin
               if (cmd == CMD_RSR) mode <= MD_STATUS;
            end else if (pend) begin
               pend <= 1'b0;
               if (cmd == CMD_CONFIRM) begin
                  mode <= MD_STATUS;
                  if (blk_locked) begin
                     sticky[BIT_ERS]  <= 1'b1;
                     sticky[BIT_PROT] <= 1'b1;
                  end else begin
                     busy <= 1'b1;
                  end
               end else begin
                  sticky[BIT_ERS] <= 1'b1;
                  sticky[BIT_SEQ] <= 1'b1;
                  mode            <= MD_ARRAY;
               end
            end else begin
               case (cmd)
                  CMD_READ:  mode <= MD_ARRAY;
                  CMD_RSR:   mode <= MD_STATUS;
                  CMD_SIG:   mode <= MD_SIG;
                  CMD_CFI:   mode <= query_next;
                  CMD_CLR: begin
                     sticky <= sticky & ~CLR_MASK[6:0];
                     mode   <= MD_ARRAY;
                  end
                  CMD_ERASE: pend <= 1'b1;
                  default:   mode <= MD_ARRAY;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/dbf_read_mux.sv
module dbf_read_mux
   import dbf_pkg::*;
#(
   parameter logic [7:0] MFR_CODE = 8'h5A,
   parameter logic [7:0] DEV_CODE = 8'hC3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            bank_sel,
   input  logic [7:0]      addr_lo,
   input  logic            lock_bit,
   input  mode_t [1:0]     bank_mode,
   input  logic [1:0][7:0] bank_stat,
   output logic            rd_valid,
   output logic [7:0]      rd_data,
   output logic [2:0]      rd_src
);
   logic [7:0] nxt_data;
   src_t       nxt_src;

   always_comb begin
      nxt_data = addr_lo;
      nxt_src  = SRC_ARRAY;
      case (bank_mode[bank_sel])
         MD_STATUS: begin
            nxt_data = bank_stat[bank_sel];
            nxt_src  = SRC_STATUS;
         end
         MD_SIG: begin
            if (!bank_sel) begin
               nxt_src = SRC_IDENT;
               case (addr_lo[1:0])
                  2'd0:    nxt_data = MFR_CODE;
                  2'd1:    nxt_data = DEV_CODE;
                  2'd2:    nxt_data = {7'd0, lock_bit};
                  default: nxt_data = 8'h00;
               endcase
            end else begin
               nxt_src  = SRC_PROT;
               nxt_data = {7'd0, lock_bit};
            end
         end
         MD_CFI: begin
            nxt_data = ~addr_lo;
            nxt_src  = SRC_CFI;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_src   <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= nxt_data;
            rd_src  <= nxt_src;
         end
      end
   end
endmodule

// File: rtl/dbflash_cmd_ctrl.sv
module dbflash_cmd_ctrl
   import dbf_pkg::*;
#(
   parameter int         ADDR_W       = 10,
   parameter int         BLK_PER_BANK = 4,
   parameter logic [7:0] MFR_CODE     = 8'h5A,
   parameter logic [7:0] DEV_CODE     = 8'hC3,
   localparam int        BLK_W        = $clog2(BLK_PER_BANK),
   localparam int        NUM_BLK      = 2 * BLK_PER_BANK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [7:0]         wdata,
   input  logic [NUM_BLK-1:0] lock_map,
   output logic               rd_valid,
   output logic [7:0]         rd_data,
   output logic [2:0]         rd_src,
   output logic               eng_start,
   output logic               eng_bank,
   output logic [BLK_W-1:0]   eng_blk,
   input  logic [1:0]         eng_done
);
   if (BLK_PER_BANK < 2 || (1 << BLK_W) != BLK_PER_BANK) begin : g_bad_blk
      $error("BLK_PER_BANK must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || ADDR_W < BLK_W + 3) begin : g_bad_addr
      $error("ADDR_W too small for bank, block and offset fields");
   end

   mode_t [1:0]      bank_mode;
   logic [1:0]       bank_busy;
   logic [1:0]       bank_pend;
   logic [1:0][7:0]  bank_stat;
   logic [1:0]       bank_start;
   logic [BLK_W:0]   lock_idx;
   logic             lock_sel;

   assign lock_idx = {addr[ADDR_W-1], addr[ADDR_W-2 -: BLK_W]};
   assign lock_sel = lock_map[lock_idx];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      dbf_bank_ctrl #(.IS_BOTTOM(b == 0)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_hit     (wr_en && (addr[ADDR_W-1] == 1'(b))),
         .cmd        (wdata),
         .blk_locked (lock_sel),
         .done       (eng_done[b]),
         .mode       (bank_mode[b]),
         .busy       (bank_busy[b]),
         .pend       (bank_pend[b]),
         .status     (bank_stat[b]),
         .start      (bank_start[b])
      );
   end

   assign eng_start = |bank_start;
   assign eng_bank  = bank_start[1];
   assign eng_blk   = lock_idx[BLK_W-1:0];

   dbf_read_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .bank_sel  (addr[ADDR_W-1]),
      .addr_lo   (addr[7:0]),
      .lock_bit  (lock_sel),
      .bank_mode (bank_mode),
      .bank_stat (bank_stat),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .rd_src    (rd_src)
   );
endmodule

// File: rtl/dbflash_cmd_chk.sv
module dbflash_cmd_chk
   import dbf_pkg::*;
#(
   parameter int BLK_W   = 2,
   parameter int NUM_BLK = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [7:0]         wdata,
   input logic               rd_en,
   input logic               rd_valid,
   input logic [NUM_BLK-1:0] lock_map,
   input logic [BLK_W:0]     sel_idx,
   input logic               eng_start,
   input logic               eng_bank,
   input logic [BLK_W-1:0]   eng_blk,
   input mode_t [1:0]        bank_mode,
   input logic [1:0]         bank_busy,
   input logic [1:0]         bank_pend,
   input logic [1:0][7:0]    bank_stat
);
   assert_reset_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> bank_mode[0] == MD_ARRAY && bank_mode[1] == MD_ARRAY && bank_busy == 2'b00);

   assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en));

   assert_start_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !lock_map[{eng_bank, eng_blk}]);

   assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> bank_busy[$past(eng_bank)]);

   for (genvar b = 0; b < 2; b++) begin : g_chk
      logic hit;
      assign hit = wr_en && (sel_idx[BLK_W] == 1'(b));

      assert_busy_read_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
         hit && bank_busy[b] && wdata == CMD_READ |=> bank_mode[b] == $past(bank_mode[b]));

      assert_status_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !bank_pend[b] && wdata == CMD_RSR |=> bank_mode[b] == MD_STATUS);

      assert_clear_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !bank_busy[b] && !bank_pend[b] && wdata == CMD_CLR
         |=> (bank_stat[b] & CLR_MASK) == 8'h00 && bank_mode[b] == MD_ARRAY);

      assert_protect_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !bank_busy[b] && bank_pend[b] && wdata == CMD_CONFIRM && lock_map[sel_idx]
         |=> bank_stat[b][5] && bank_stat[b][1] && !bank_busy[b]);

      assert_seq_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !bank_busy[b] && bank_pend[b] && wdata != CMD_CONFIRM
         |=> bank_stat[b][5] && bank_stat[b][4] && bank_mode[b] == MD_ARRAY);

      assert_other_bank_R13: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && (sel_idx[BLK_W] != 1'(b))
         |=> bank_mode[b] == $past(bank_mode[b]) && bank_pend[b] == $past(bank_pend[b]));
   end
endmodule

bind dbflash_cmd_ctrl dbflash_cmd_chk #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wdata     (wdata),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .lock_map  (lock_map),
   .sel_idx   (lock_idx),
   .eng_start (eng_start),
   .eng_bank  (eng_bank),
   .eng_blk   (eng_blk),
   .bank_mode (bank_mode),
   .bank_busy (bank_busy),
   .bank_pend (bank_pend),
   .bank_stat (bank_stat)
);

// File: tb/dbflash_cmd_ctrl_tb_top.sv
module dbflash_cmd_ctrl_tb_top;
   localparam int ADDR_W = 10;
   localparam int BLK_PER_BANK = 4;
   localparam int BLK_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        wdata = '0;
   logic [7:0]        lock_map = 8'b0100_0010; // bottom blk1, top blk2 locked
   logic              rd_valid;
   logic [7:0]        rd_data;
   logic [2:0]        rd_src;
   logic              eng_start;
   logic              eng_bank;
   logic [BLK_W-1:0]  eng_blk;
   logic [1:0]        eng_done = 2'b00;

   int errors = 0;
   int checks = 0;
   logic start_seen, bank_seen;
   logic [BLK_W-1:0] blk_seen;

   always #5 clk = ~clk;

   dbflash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_PER_BANK(BLK_PER_BANK)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .lock_map(lock_map), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_src(rd_src), .eng_start(eng_start), .eng_bank(eng_bank),
      .eng_blk(eng_blk), .eng_done(eng_done)
   );

   typedef struct packed {
      logic       rd;
      logic [9:0] a;
      logic [7:0] d;
      logic [2:0] s;
      logic [3:0] r;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 10'h005, 8'h05, 3'd0, 4'd1},  // R1 bottom array
      '{1'b1, 10'h203, 8'h03, 3'd0, 4'd1},  // R1 top array
      '{1'b0, 10'h000, 8'h90, 3'd0, 4'd5},  // R5 bottom ident
      '{1'b1, 10'h000, 8'h5A, 3'd2, 4'd5},
      '{1'b1, 10'h001, 8'hC3, 3'd2, 4'd5},
      '{1'b1, 10'h082, 8'h01, 3'd2, 4'd5},
      '{1'b1, 10'h002, 8'h00, 3'd2, 4'd5},
      '{1'b1, 10'h210, 8'h10, 3'd0, 4'd13}, // R13 top unaffected
      '{1'b0, 10'h200, 8'h90, 3'd0, 4'd5},  // R5 top protection only
      '{1'b1, 10'h300, 8'h01, 3'd3, 4'd5},
      '{1'b1, 10'h200, 8'h00, 3'd3, 4'd5},
      '{1'b1, 10'h000, 8'h5A, 3'd2, 4'd13}, // R13
      '{1'b0, 10'h000, 8'h98, 3'd0, 4'd6},  // R6 bottom query
      '{1'b1, 10'h011, 8'hEE, 3'd4, 4'd6},
      '{1'b1, 10'h300, 8'h01, 3'd3, 4'd13}, // R13
      '{1'b0, 10'h200, 8'h98, 3'd0, 4'd6},  // R6 top query invalid
      '{1'b1, 10'h215, 8'h15, 3'd0, 4'd6},
      '{1'b0, 10'h000, 8'h70, 3'd0, 4'd4},  // R4
      '{1'b1, 10'h000, 8'h80, 3'd1, 4'd4},
      '{1'b0, 10'h000, 8'hFF, 3'd0, 4'd2},  // R2
      '{1'b1, 10'h044, 8'h44, 3'd0, 4'd2},
      '{1'b0, 10'h000, 8'h90, 3'd0, 4'd11}, // R11
      '{1'b0, 10'h000, 8'h3C, 3'd0, 4'd11},
      '{1'b1, 10'h006, 8'h06, 3'd0, 4'd11}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      #1;
      start_seen = eng_start; bank_seen = eng_bank; blk_seen = eng_blk;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [9:0] a, input logic [7:0] d, input logic [2:0] s,
                        input string tag);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, {rd_valid, rd_data, 5'd0, rd_src}, {1'b1, d, 5'd0, s});
   endtask

   task automatic pulse_done(input int b);
      eng_done[b] = 1'b1;
      @(negedge clk);
      eng_done = 2'b00;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {31'd0, rd_valid}, 0);
      chk("R1", {31'd0, eng_start}, 0);
      do_wr(10'h000, 8'h70);
      do_rd(10'h000, 8'h80, 3'd1, "R1");
      do_wr(10'h000, 8'hFF);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) do_rd(VEC[i].a, VEC[i].d, VEC[i].s, $sformatf("R%0d vec%0d", VEC[i].r, i));
         else           do_wr(VEC[i].a, VEC[i].d);
      end

      // R9 protected block
      do_wr(10'h080, 8'h20); do_wr(10'h080, 8'hD0);
      chk("R9", {31'd0, start_seen}, 0);
      do_rd(10'h000, 8'hA2, 3'd1, "R9");
      // R8 start on unlocked, R12 errors persist
      do_wr(10'h000, 8'h20); do_wr(10'h000, 8'hD0);
      chk("R8", {29'd0, start_seen, bank_seen, 1'b0}, {29'd0, 1'b1, 1'b0, 1'b0});
      chk("R8", {30'd0, blk_seen}, 0);
      do_rd(10'h000, 8'h22, 3'd1, "R12");
      // R3 commands to busy bank ignored
      do_wr(10'h000, 8'hFF);
      do_rd(10'h010, 8'h22, 3'd1, "R3");
      do_wr(10'h000, 8'h90);
      do_rd(10'h000, 8'h22, 3'd1, "R3");
      do_wr(10'h200, 8'h70);
      do_rd(10'h200, 8'h80, 3'd1, "R13");
      do_wr(10'h200, 8'hFF);
      do_rd(10'h205, 8'h05, 3'd0, "R3");
      pulse_done(0);
      do_rd(10'h000, 8'hA2, 3'd1, "R8");
      // R7 clear
      do_wr(10'h000, 8'h50);
      do_rd(10'h033, 8'h33, 3'd0, "R7");
      do_wr(10'h000, 8'h70);
      do_rd(10'h000, 8'h80, 3'd1, "R7");
      // R10 wrong confirm
      do_wr(10'h000, 8'h20); do_wr(10'h000, 8'h55);
      do_rd(10'h012, 8'h12, 3'd0, "R10");
      do_wr(10'h000, 8'h70);
      do_rd(10'h000, 8'hB0, 3'd1, "R10");
      // R8 top bank erase
      do_wr(10'h200, 8'h20); do_wr(10'h380, 8'hD0);
      chk("R8", {29'd0, start_seen, bank_seen, 1'b0}, {29'd0, 1'b1, 1'b1, 1'b0});
      chk("R8", {30'd0, blk_seen}, 3);
      do_rd(10'h200, 8'h00, 3'd1, "R8");
      do_rd(10'h000, 8'hB0, 3'd1, "R13");
      pulse_done(1);
      do_rd(10'h200, 8'h80, 3'd1, "R8");
      // R11 unknown byte keeps status
      do_wr(10'h000, 8'h3C);
      do_rd(10'h001, 8'h01, 3'd0, "R11");
      do_wr(10'h000, 8'h70);
      do_rd(10'h000, 8'hB0, 3'd1, "R11");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule